// File: doc/BRIEF.md
# Infoframe Packet Assembler

This block turns one auxiliary information packet into a short burst of 32-bit register writes. The host presents a type code, a version code, a payload length and a byte array, then pulses a start strobe. The block captures everything and works out the checksum byte that makes the whole packet sum to zero. It places that checksum in payload position 0 and emits the header word. It then cuts the payload into 7-byte subpackets, each written as a low word and a high word.

The burst ends with a write of the frame's control word: bit 0 is set to enable sending, or cleared when the link runs video-only. In video-only mode the header and subpackets are skipped and only the cleared control word is written. A one-cycle done pulse follows the last write. Audio-type frames (type 0x84) always pack exactly six bytes into a single subpacket, because the sink side pads the rest.

Top module: `ifp_assembler`

## Requirements
- R1: While reset is asserted and after it is released with no start, `wr_en_o` and `done_o` stay 0.
- R2: The first write of a normal frame goes to `hdr_addr_i`. Its data holds the type in bits 7:0, the version in bits 15:8, length minus one in bits 19:16, and zeros in bits 31:20.
- R3: Payload byte 0 is replaced by a checksum. The type, the version, (length minus one) and the checksum plus bytes 1 to length-1 sum to 0 modulo 256.
- R4: Subpacket k is written as a low word at `hdr_addr_i`+1+2k, holding bytes 7k..7k+3 with the lowest byte in bits 7:0. It is followed by a high word at `hdr_addr_i`+2+2k, holding bytes 7k+4..7k+6 in bits 23:0, with bits 31:24 zero.
- R5: The number of subpackets is ceil(length/7). Byte positions at or beyond the length read as 0, whatever the payload input holds there.
- R6: For type 0x84 exactly one subpacket is written, carrying bytes 0..5 (zero where beyond the length) with byte 6 zero. The header still carries the given length, and the checksum still covers all given bytes.
- R7: After the last subpacket, one write of value 1 goes to `ctrl_addr_i`.
- R8: With `video_only_i` set at start, the only write is value 0 to `ctrl_addr_i`.
- R9: A start pulse while a frame is in progress is ignored: the running burst is unchanged and no extra frame follows.
- R10: All writes of one frame fall on consecutive cycles in ascending order. `done_o` is high for exactly one cycle, in the cycle right after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame; taken only when idle |
| video_only_i | input | 1 | Video-only link: write a cleared control word only |
| type_i | input | 8 | Frame type code |
| version_i | input | 8 | Frame version code |
| len_i | input | LEN_W | Payload length in bytes, checksum byte included (1..MAX_BYTES) |
| payload_i | input | 8*MAX_BYTES | Payload bytes, byte i in bits 8i+7:8i; byte 0 is overwritten |
| hdr_addr_i | input | ADDR_W | Word offset of the header register |
| ctrl_addr_i | input | ADDR_W | Word offset of the control register |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | ADDR_W | Write word offset |
| wr_data_o | output | 32 | Write data |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench fills the payload beyond the length with non-zero filler. A block that failed to mask those positions would leak them into the final partial subpacket or into the sum. Lengths of 1, 7, 9 and 14 place the end of the payload at every subpacket edge. An off-by-one in the subpacket count would drop the trailing high word or add an extra pair. An audio frame with a long payload catches a design that packs all of its bytes, or that also shortens the checksum. A start injected mid-burst with different fields would, if accepted, corrupt the header or append a second burst.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_SUB,
        S_CTRL,
        S_FIN
    } ifp_state_e;

    localparam logic [7:0] AUDIO_TYPE  = 8'h84;
    localparam int         AUDIO_BYTES = 6;
    localparam int         SUB_BYTES   = 7;

endpackage

// File: rtl/ifp_csum.sv
module ifp_csum #(
    parameter int MAX_BYTES = 14,
    parameter int LEN_W     = 4
) (
    input  logic [7:0]             type_i,
    input  logic [7:0]             version_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [8*MAX_BYTES-1:0] bytes_i,
    output logic [7:0]             csum_o
);

    logic [7:0] masked [MAX_BYTES];
    logic [7:0] acc;

    generate
        for (genvar g = 0; g < MAX_BYTES; g++) begin : g_mask
            if (g == 0) begin : g_first
                assign masked[g] = 8'h00;
            end else begin : g_rest
                assign masked[g] = (32'(g) < 32'(len_i)) ? bytes_i[8*g +: 8] : 8'h00;
            end
        end
    endgenerate

    always_comb begin
        acc = type_i + version_i + (8'(len_i) - 8'd1);
        for (int i = 0; i < MAX_BYTES; i++) begin
            acc = acc + masked[i];
        end
        csum_o = 8'h00 - acc;
    end

endmodule

// File: rtl/ifp_subpack.sv
module ifp_subpack #(
    parameter int MAX_BYTES = 14,
    parameter int LEN_W     = 4,
    parameter int SUB_W     = 2
) (
    input  logic [8*MAX_BYTES-1:0] frame_i,
    input  logic [LEN_W-1:0]       fill_i,
    input  logic [SUB_W-1:0]       idx_i,
    output logic [31:0]            lo_o,
    output logic [31:0]            hi_o
);
    import ifp_pkg::*;

    localparam int NSUB   = (MAX_BYTES + SUB_BYTES - 1) / SUB_BYTES;
    localparam int PADDED = NSUB * SUB_BYTES;

    logic [7:0] padded [PADDED];
    logic [7:0] sel    [SUB_BYTES];

    generate
        for (genvar p = 0; p < PADDED; p++) begin : g_pad
            if (p < MAX_BYTES) begin : g_real
                assign padded[p] = (32'(p) < 32'(fill_i)) ? frame_i[8*p +: 8] : 8'h00;
            end else begin : g_zero
                assign padded[p] = 8'h00;
            end
        end
    endgenerate

    always_comb begin
        for (int j = 0; j < SUB_BYTES; j++) begin
            sel[j] = 8'h00;
            for (int k = 0; k < NSUB; k++) begin
                if (32'(idx_i) == k) begin
                    sel[j] = padded[k*SUB_BYTES + j];
                end
            end
        end
        lo_o = {sel[3], sel[2], sel[1], sel[0]};
        hi_o = {8'h00, sel[6], sel[5], sel[4]};
    end

endmodule

// File: rtl/ifp_assembler.sv
module ifp_assembler #(
    parameter int MAX_BYTES = 14,
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   video_only_i,
    input  logic [7:0]             type_i,
    input  logic [7:0]             version_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [8*MAX_BYTES-1:0] payload_i,
    input  logic [ADDR_W-1:0]      hdr_addr_i,
    input  logic [ADDR_W-1:0]      ctrl_addr_i,
    output logic                   wr_en_o,
    output logic [ADDR_W-1:0]      wr_addr_o,
    output logic [31:0]            wr_data_o,
    output logic                   done_o
);
    import ifp_pkg::*;

    localparam int NSUB  = (MAX_BYTES + SUB_BYTES - 1) / SUB_BYTES;
    localparam int SUB_W = $clog2(NSUB + 1);

    typedef struct packed {
        ifp_state_e             st;
        logic [7:0]             typ;
        logic [7:0]             ver;
        logic [LEN_W-1:0]       len;
        logic [8*MAX_BYTES-1:0] pay;
        logic [ADDR_W-1:0]      base;
        logic [ADDR_W-1:0]      ctrl;
        logic                   vonly;
        logic [SUB_W-1:0]       idx;
        logic                   hi;
        logic                   wr_en;
        logic [ADDR_W-1:0]      wr_addr;
        logic [31:0]            wr_data;
        logic                   done;
    } regs_t;

    regs_t q, d;

    logic [7:0]             csum;
    logic                   is_audio;
    logic [LEN_W-1:0]       eff_len;
    logic [LEN_W-1:0]       fill_len;
    logic [SUB_W-1:0]       nsub;
    logic [8*MAX_BYTES-1:0] frame;
    logic [31:0]            sub_lo;
    logic [31:0]            sub_hi;

    ifp_csum #(
        .MAX_BYTES(MAX_BYTES),
        .LEN_W    (LEN_W)
    ) u_csum (
        .type_i   (q.typ),
        .version_i(q.ver),
        .len_i    (q.len),
        .bytes_i  (q.pay),
        .csum_o   (csum)
    );

    always_comb begin
        is_audio = (q.typ == AUDIO_TYPE);
        eff_len  = is_audio ? LEN_W'(AUDIO_BYTES) : q.len;
        fill_len = (is_audio && (32'(q.len) > AUDIO_BYTES)) ? LEN_W'(AUDIO_BYTES) : q.len;
        nsub     = SUB_W'((32'(eff_len) + SUB_BYTES - 1) / SUB_BYTES);
        frame    = q.pay;
        frame[7:0] = csum;
    end

    ifp_subpack #(
        .MAX_BYTES(MAX_BYTES),
        .LEN_W    (LEN_W),
        .SUB_W    (SUB_W)
    ) u_subpack (
        .frame_i(frame),
        .fill_i (fill_len),
        .idx_i  (q.idx),
        .lo_o   (sub_lo),
        .hi_o   (sub_hi)
    );

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.done    = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.typ   = type_i;
                    d.ver   = version_i;
                    d.len   = len_i;
                    d.pay   = payload_i;
                    d.base  = hdr_addr_i;
                    d.ctrl  = ctrl_addr_i;
                    d.vonly = video_only_i;
                    d.idx   = '0;
                    d.hi    = 1'b0;
                    d.st    = video_only_i ? S_CTRL : S_HDR;
                end
            end
            S_HDR: begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.base;
                d.wr_data = {12'h000, 4'(q.len - 1'b1), q.ver, q.typ};
                d.st      = (nsub == '0) ? S_CTRL : S_SUB;
            end
            S_SUB: begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.base + ADDR_W'(1) + ADDR_W'({q.idx, 1'b0}) + ADDR_W'(q.hi);
                d.wr_data = q.hi ? sub_hi : sub_lo;
                if (q.hi) begin
                    d.hi  = 1'b0;
                    d.idx = q.idx + 1'b1;
                    if ((q.idx + 1'b1) == nsub) begin
                        d.st = S_CTRL;
                    end
                end else begin
                    d.hi = 1'b1;
                end
            end
            S_CTRL: begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.ctrl;
                d.wr_data = {31'h0, ~q.vonly};
                d.st      = S_FIN;
            end
            S_FIN: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;
    assign done_o    = q.done;

    logic [ADDR_W-1:0] hdr_base_q;
    logic [ADDR_W-1:0] ctrl_addr_q;
    logic              video_only_q;
    logic              busy_q;

    assign hdr_base_q   = q.base;
    assign ctrl_addr_q  = q.ctrl;
    assign video_only_q = q.vonly;
    assign busy_q       = (q.st != S_IDLE);

endmodule

// File: rtl/ifp_assembler_chk.sv
module ifp_assembler_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [31:0]       wr_data_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] hdr_base_q,
    input logic [ADDR_W-1:0] ctrl_addr_q,
    input logic              video_only_q,
    input logic              busy_q
);

    logic [ADDR_W-1:0] rel;
    assign rel = wr_addr_o - hdr_base_q;

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_en_o) && $past(wr_addr_o) == ctrl_addr_q);

    a_r8_video_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && video_only_q) |-> (wr_data_o == 32'h0 && wr_addr_o == ctrl_addr_q));

    a_r4_pad_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !video_only_q && wr_addr_o != ctrl_addr_q && rel != '0 && !rel[0])
        |-> wr_data_o[31:24] == 8'h00);

    a_r9_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(hdr_base_q) && $stable(video_only_q)));

    a_r2_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !$past(wr_en_o)) |-> (wr_addr_o == hdr_base_q || wr_addr_o == ctrl_addr_q));

endmodule

bind ifp_assembler ifp_assembler_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .done_o      (done_o),
    .hdr_base_q  (hdr_base_q),
    .ctrl_addr_q (ctrl_addr_q),
    .video_only_q(video_only_q),
    .busy_q      (busy_q)
);

// File: tb/ifp_assembler_bench.sv
`timescale 1ns/1ps
module ifp_assembler_bench;
    localparam int MAXB = 14;
    localparam int AW   = 8;
    localparam int LW   = 4;
    localparam int NV   = 6;

    localparam logic [7:0] V_TYP  [NV] = '{8'h82, 8'h84, 8'h83, 8'h81, 8'h82, 8'h82};
    localparam logic [7:0] V_VER  [NV] = '{8'h02, 8'h01, 8'h01, 8'h01, 8'h02, 8'h02};
    localparam int         V_LEN  [NV] = '{14, 11, 9, 1, 7, 14};
    localparam bit         V_VO   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [7:0] V_SEED [NV] = '{8'h11, 8'h40, 8'h05, 8'hA0, 8'hFF, 8'h22};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              vonly = 1'b0;
    logic [7:0]        typ = '0, ver = '0;
    logic [LW-1:0]     len = '0;
    logic [8*MAXB-1:0] pay = '0;
    logic [AW-1:0]     base = '0, ctrl = '0;
    logic              wr_en, done;
    logic [AW-1:0]     wr_addr;
    logic [31:0]       wr_data;

    ifp_assembler #(.MAX_BYTES(MAXB), .ADDR_W(AW)) u_ifp_assembler (
        .clk(clk), .rst_n(rst_n), .start_i(start), .video_only_i(vonly),
        .type_i(typ), .version_i(ver), .len_i(len), .payload_i(pay),
        .hdr_addr_i(base), .ctrl_addr_i(ctrl),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [AW-1:0] ea [8];
    logic [31:0]   ed [8];
    string         et [8];
    int            en;
    logic [AW-1:0] aa [8];
    logic [31:0]   ad [8];
    int            an, first_at, done_at;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [8*MAXB-1:0] mk_pay(input logic [7:0] seed);
        logic [8*MAXB-1:0] p;
        for (int i = 0; i < MAXB; i++) p[8*i +: 8] = seed + 8'(i * 37);
        return p;
    endfunction

    task automatic build_exp(input logic [7:0] t, input logic [7:0] v, input int l,
                             input bit vo, input logic [7:0] seed,
                             input logic [AW-1:0] b, input logic [AW-1:0] c);
        logic [7:0] by [21];
        logic [7:0] s;
        int eff, ns;
        string tg;
        en = 0;
        if (!vo) begin
            for (int i = 0; i < 21; i++) by[i] = (i < l) ? seed + 8'(i * 37) : 8'h00;
            s = t + v + 8'(l - 1);
            for (int i = 1; i < l; i++) s = s + by[i];
            by[0] = 8'h00 - s;
            eff = (t == 8'h84) ? 6 : l;
            for (int i = eff; i < 21; i++) by[i] = 8'h00;
            ns = (eff + 6) / 7;
            tg = (t == 8'h84) ? "R6" : ((l % 7) != 0 ? "R5" : "R4");
            ea[0] = b; ed[0] = {12'h000, 4'(l - 1), v, t}; et[0] = "R2"; en = 1;
            for (int k = 0; k < ns; k++) begin
                ea[en] = b + AW'(1 + 2*k);
                ed[en] = {by[7*k+3], by[7*k+2], by[7*k+1], by[7*k]};
                et[en] = tg; en++;
                ea[en] = b + AW'(2 + 2*k);
                ed[en] = {8'h00, by[7*k+6], by[7*k+5], by[7*k+4]};
                et[en] = tg; en++;
            end
        end
        ea[en] = c; ed[en] = vo ? 32'h0 : 32'h1; et[en] = vo ? "R8" : "R7"; en++;
    endtask

    task automatic run(input logic [7:0] t, input logic [7:0] v, input int l,
                       input bit vo, input logic [7:0] seed,
                       input logic [AW-1:0] b, input logic [AW-1:0] c, input bit inject);
        @(negedge clk);
        typ = t; ver = v; len = LW'(l); vonly = vo; pay = mk_pay(seed);
        base = b; ctrl = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        an = 0; first_at = -1; done_at = -1;
        for (int cc = 0; cc < 40; cc++) begin
            @(negedge clk);
            if (wr_en) begin
                if (first_at < 0) first_at = cc;
                if (an < 8) begin aa[an] = wr_addr; ad[an] = wr_data; end
                an++;
            end
            if (done) begin done_at = cc; break; end
            if (inject && cc == 1) begin
                start = 1'b1; typ = 8'h83; len = LW'(3); vonly = 1'b1;
                base = 8'hE0; pay = mk_pay(8'h99);
            end
            if (inject && cc == 2) start = 1'b0;
        end
        @(negedge clk);
        chk(!done, "R10", "done single cycle", 32'(done), 32'h0);
    endtask

    task automatic compare(input logic [7:0] t, input int l, input bit vo);
        logic [7:0] s;
        chk(an == en, "R10", "write count", 32'(an), 32'(en));
        for (int i = 0; i < en && i < an; i++) begin
            chk(aa[i] == ea[i], et[i], "address", 32'(aa[i]), 32'(ea[i]));
            chk(ad[i] == ed[i], et[i], "data", ad[i], ed[i]);
        end
        chk(done_at == first_at + an, "R10", "consecutive writes then done",
            32'(done_at), 32'(first_at + an));
        if (!vo && t != 8'h84 && an == en) begin
            s = ad[0][7:0] + ad[0][15:8] + {4'h0, ad[0][19:16]};
            for (int i = 1; i < an - 1; i++)
                s = s + ad[i][7:0] + ad[i][15:8] + ad[i][23:16] + ad[i][31:24];
            chk(s == 8'h00, "R3", "packet byte sum", 32'(s), 32'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!wr_en && !done, "R1", "outputs in reset", {wr_en, done}, 32'h0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!wr_en && !done, "R1", "idle after reset", {wr_en, done}, 32'h0);
        end

        for (int v = 0; v < NV; v++) begin
            build_exp(V_TYP[v], V_VER[v], V_LEN[v], V_VO[v], V_SEED[v],
                      8'h20 + AW'(v * 16), 8'h08 + AW'(v));
            run(V_TYP[v], V_VER[v], V_LEN[v], V_VO[v], V_SEED[v],
                8'h20 + AW'(v * 16), 8'h08 + AW'(v), 1'b0);
            compare(V_TYP[v], V_LEN[v], V_VO[v]);
        end

        // R6: short audio frame, bytes past the length must be zero
        build_exp(8'h84, 8'h01, 3, 1'b0, 8'h5A, 8'h40, 8'h30);
        run(8'h84, 8'h01, 3, 1'b0, 8'h5A, 8'h40, 8'h30, 1'b0);
        compare(8'h84, 3, 1'b0);

        // R9: start while busy is ignored
        build_exp(8'h82, 8'h02, 13, 1'b0, 8'h33, 8'h50, 8'h04);
        run(8'h82, 8'h02, 13, 1'b0, 8'h33, 8'h50, 8'h04, 1'b1);
        compare(8'h82, 13, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!wr_en && !done, "R9", "no frame from ignored start", {wr_en, done}, 32'h0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule